// File: doc/BRIEF.md
# Serial Mouse Packet Decoder

This block turns the byte stream of a slow serial pointing device into discrete input events. Each input byte arrives with a valid strobe and a line-error flag, which covers framing and parity faults. The stream is organised as five-byte packets. The first byte holds the three button states in inverted form. The four bytes after it are signed movement deltas that alternate between the X axis and the Y axis. The block keeps the current button mask and two running movement sums. It tracks which button state the consumer has already been told about.

When the last byte of a packet is accepted, the block pushes events into a downstream queue, one per cycle. Button events come first, one event per changed button. After them come one X event and one Y event. A delta event is sent only when its sum is nonzero. If the queue reports full, emission stops at once. Any change that has not been sent is kept and merged with the packets that follow. Movement sums saturate instead of wrapping. A reserved range of first-byte values lets the decoder find the packet boundary again after noise. Line errors make the decoder drop alignment.

Top module: `mouse_pkt_decoder`

## Requirements
- R1: After reset the decoder is out of alignment, both button masks and both sums are zero, and `ev_valid_o` is low. A packet that reports no button pressed and carries all-zero deltas then produces no event.
- R2: A byte without a line error whose value lies in 0x80..0x87 is a button byte. It restarts the packet at the delta-X position, whatever position the decoder was at. Deltas already added to the sums are kept.
- R3: The pressed mask is the bitwise inverse of bits 2..0 of the button byte. Bit 2 is left (ID 2), bit 1 is middle (ID 1) and bit 0 is right (ID 0). `ev_btn_o` carries this ID.
- R4: A byte flagged with a line error puts the decoder out of alignment. From then on every byte is discarded until a button byte arrives.
- R5: A delta byte is a two's-complement 8-bit value, and it is added to its sum. The sum is never loaded from the byte. Packet positions 1 and 3 feed X, and positions 2 and 4 feed Y.
- R6: Events start in the cycle after the fifth byte is accepted. After the fifth byte the decoder is out of alignment, so a further non-button byte is ignored.
- R7: While the pressed mask and the reported mask differ, the block emits one button event for the highest differing bit and then flips that bit in the reported mask. `ev_down_o` is 1 when that button is now pressed and 0 when it is released.
- R8: After the button events, the block emits an X event (kind 1) carrying the X sum if that sum is nonzero, then a Y event (kind 2) carrying the Y sum if that sum is nonzero. Button events are kind 0. A sum is cleared when its event is sent.
- R9: While `ev_full_i` is high no event is emitted and the current emission stops. Unsent button changes and nonzero sums are carried into the emission of a later packet.
- R10: While `enable_i` is low, input bytes have no effect on the packet position, the masks or the sums.
- R11: Each sum saturates at +32767 and -32768 (16-bit default) instead of wrapping.
- R12: A delta byte accepted in the same cycle that its axis's sum is sent becomes the new sum. It is neither lost nor added to the value that was sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Input accepted only while high |
| byte_valid_i | input | 1 | Received byte strobe |
| byte_i | input | 8 | Received byte value |
| byte_err_i | input | 1 | Framing or parity error on this byte |
| ev_full_i | input | 1 | Downstream queue full |
| ev_valid_o | output | 1 | Event pushed this cycle |
| ev_kind_o | output | 2 | 0 button, 1 X delta, 2 Y delta |
| ev_btn_o | output | 2 | Button ID (2 left, 1 middle, 0 right) |
| ev_down_o | output | 1 | 1 pressed, 0 released |
| ev_delta_o | output | DELTA_W | Signed movement value |

## Verification
The collision of interest is between an X event being sent, which clears the X sum, and a new delta-X byte, which adds to the X sum. Both can land in the same cycle. The bench provokes this by sending a packet with a button change and an X delta, then starting the next packet immediately with no idle cycles. With that timing, the next packet's first delta-X byte arrives in exactly the cycle the pending X event leaves. The scoreboard then expects a later X event equal to the new byte alone. A value of zero or of the old sum plus the new byte is reported as a failure.

// File: rtl/mouse_dec_pkg.sv
package mouse_dec_pkg;
  localparam int BTN_N   = 3;
  localparam int BTN_IDW = 2;

  typedef enum logic [1:0] {
    EV_BTN = 2'd0,
    EV_DX  = 2'd1,
    EV_DY  = 2'd2
  } ev_kind_e;

  typedef enum logic [2:0] {
    P_UNSYNC = 3'd0,
    P_DX1    = 3'd1,
    P_DY1    = 3'd2,
    P_DX2    = 3'd3,
    P_DY2    = 3'd4
  } pkt_pos_e;
endpackage

// File: rtl/mouse_pkt_framer.sv
module mouse_pkt_framer
  import mouse_dec_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    byte_valid_i,
  input  logic [7:0]              byte_i,
  input  logic                    byte_err_i,
  output pkt_pos_e                pos_o,
  output logic [BTN_N-1:0]        pressed_o,
  output logic                    add_x_o,
  output logic                    add_y_o,
  output logic signed [7:0]       delta_o,
  output logic                    pkt_done_o
);
  pkt_pos_e pos_q, pos_d;
  logic [BTN_N-1:0] pressed_q;
  logic take, good, is_btn, is_delta;

  assign take     = en_i & byte_valid_i;
  assign good     = take & ~byte_err_i;
  assign is_btn   = (byte_i[7:3] == 5'b10000);
  assign is_delta = good & ~is_btn;

  always_comb begin
    pos_d = pos_q;
    if (take && byte_err_i)  pos_d = P_UNSYNC;
    else if (good && is_btn) pos_d = P_DX1;
    else if (is_delta) begin
      unique case (pos_q)
        P_DX1:   pos_d = P_DY1;
        P_DY1:   pos_d = P_DX2;
        P_DX2:   pos_d = P_DY2;
        default: pos_d = P_UNSYNC;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q     <= P_UNSYNC;
      pressed_q <= '0;
    end else begin
      pos_q <= pos_d;
      if (good && is_btn) pressed_q <= ~byte_i[BTN_N-1:0];
    end
  end

  assign pos_o      = pos_q;
  assign pressed_o  = pressed_q;
  assign delta_o    = signed'(byte_i);
  assign add_x_o    = is_delta & ((pos_q == P_DX1) | (pos_q == P_DX2));
  assign add_y_o    = is_delta & ((pos_q == P_DY1) | (pos_q == P_DY2));
  assign pkt_done_o = is_delta & (pos_q == P_DY2);
endmodule

// File: rtl/mouse_sat_acc.sv
module mouse_sat_acc #(
  parameter int W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                add_i,
  input  logic signed [7:0]   delta_i,
  output logic signed [W-1:0] acc_o
);
  localparam logic signed [W:0] SMAX = {2'b00, {(W-1){1'b1}}};
  localparam logic signed [W:0] SMIN = {2'b11, {(W-1){1'b0}}};

  logic signed [W-1:0] acc_q, base;
  logic signed [W:0]   sum;
  logic signed [W-1:0] acc_d;

  always_comb begin
    base = clr_i ? '0 : acc_q;
    sum  = signed'({base[W-1], base}) + signed'({{(W-7){delta_i[7]}}, delta_i});
    if (!add_i)         acc_d = base;
    else if (sum > SMAX) acc_d = SMAX[W-1:0];
    else if (sum < SMIN) acc_d = SMIN[W-1:0];
    else                acc_d = sum[W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             acc_q <= '0;
    else if (clr_i || add_i) acc_q <= acc_d;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/mouse_evt_emitter.sv
module mouse_evt_emitter
  import mouse_dec_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                pkt_done_i,
  input  logic                full_i,
  input  logic [BTN_N-1:0]    pressed_i,
  input  logic signed [W-1:0] acc_x_i,
  input  logic signed [W-1:0] acc_y_i,
  output logic                ev_valid_o,
  output ev_kind_e            ev_kind_o,
  output logic [BTN_IDW-1:0]  ev_btn_o,
  output logic                ev_down_o,
  output logic signed [W-1:0] ev_delta_o,
  output logic                clr_x_o,
  output logic                clr_y_o,
  output logic                pending_o,
  output logic [BTN_N-1:0]    reported_o
);
  logic [BTN_N-1:0]   reported_q, diff, flip;
  logic [BTN_IDW-1:0] hi;
  logic               pending_q, have_btn, have_x, have_y, any_ev;

  assign diff = pressed_i ^ reported_q;

  // highest changed button wins
  always_comb begin
    hi = '0;
    for (int i = 0; i < BTN_N; i++)
      if (diff[i]) hi = BTN_IDW'(i);
    flip     = '0;
    flip[hi] = 1'b1;
  end

  assign have_btn = |diff;
  assign have_x   = (acc_x_i != '0);
  assign have_y   = (acc_y_i != '0);
  assign any_ev   = have_btn | have_x | have_y;

  assign ev_valid_o = pending_q & any_ev & ~full_i;
  assign ev_kind_o  = have_btn ? EV_BTN : (have_x ? EV_DX : EV_DY);
  assign ev_btn_o   = hi;
  assign ev_down_o  = have_btn & pressed_i[hi];
  assign ev_delta_o = have_btn ? '0 : (have_x ? acc_x_i : acc_y_i);
  assign clr_x_o    = ev_valid_o & (ev_kind_o == EV_DX);
  assign clr_y_o    = ev_valid_o & (ev_kind_o == EV_DY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reported_q <= '0;
      pending_q  <= 1'b0;
    end else begin
      if (ev_valid_o && have_btn) reported_q <= reported_q ^ flip;
      if (pkt_done_i)                          pending_q <= 1'b1;
      else if (pending_q && (!any_ev || full_i)) pending_q <= 1'b0;
    end
  end

  assign pending_o  = pending_q;
  assign reported_o = reported_q;
endmodule

// File: rtl/mouse_pkt_decoder.sv
module mouse_pkt_decoder
  import mouse_dec_pkg::*;
#(
  parameter int DELTA_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enable_i,
  input  logic               byte_valid_i,
  input  logic [7:0]         byte_i,
  input  logic               byte_err_i,
  input  logic               ev_full_i,
  output logic               ev_valid_o,
  output logic [1:0]         ev_kind_o,
  output logic [1:0]         ev_btn_o,
  output logic               ev_down_o,
  output logic [DELTA_W-1:0] ev_delta_o
);
  localparam int AXES = 2;

  pkt_pos_e             pos;
  logic [BTN_N-1:0]     pressed, reported;
  logic                 pkt_done, pending;
  logic signed [7:0]    delta;
  logic [AXES-1:0]      add, clr;
  logic signed [DELTA_W-1:0] acc [AXES];
  logic signed [DELTA_W-1:0] acc_x, acc_y, ev_delta;
  ev_kind_e             ev_kind;
  logic [BTN_IDW-1:0]   ev_btn;

  mouse_pkt_framer u_framer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (enable_i),
    .byte_valid_i (byte_valid_i),
    .byte_i       (byte_i),
    .byte_err_i   (byte_err_i),
    .pos_o        (pos),
    .pressed_o    (pressed),
    .add_x_o      (add[0]),
    .add_y_o      (add[1]),
    .delta_o      (delta),
    .pkt_done_o   (pkt_done)
  );

  for (genvar a = 0; a < AXES; a++) begin : g_axis
    mouse_sat_acc #(.W(DELTA_W)) u_acc (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (clr[a]),
      .add_i   (add[a]),
      .delta_i (delta),
      .acc_o   (acc[a])
    );
  end

  assign acc_x = acc[0];
  assign acc_y = acc[1];

  mouse_evt_emitter #(.W(DELTA_W)) u_emit (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pkt_done_i (pkt_done),
    .full_i     (ev_full_i),
    .pressed_i  (pressed),
    .acc_x_i    (acc_x),
    .acc_y_i    (acc_y),
    .ev_valid_o (ev_valid_o),
    .ev_kind_o  (ev_kind),
    .ev_btn_o   (ev_btn),
    .ev_down_o  (ev_down_o),
    .ev_delta_o (ev_delta),
    .clr_x_o    (clr[0]),
    .clr_y_o    (clr[1]),
    .pending_o  (pending),
    .reported_o (reported)
  );

  assign ev_kind_o  = ev_kind;
  assign ev_btn_o   = 2'(ev_btn);
  assign ev_delta_o = ev_delta;
endmodule

// File: rtl/mouse_dec_checker.sv
module mouse_dec_checker
  import mouse_dec_pkg::*;
#(
  parameter int DELTA_W = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                enable_i,
  input logic                byte_valid_i,
  input logic [7:0]          byte_i,
  input logic                byte_err_i,
  input logic                ev_full_i,
  input logic                ev_valid_o,
  input logic [1:0]          ev_kind_o,
  input logic [1:0]          ev_btn_o,
  input logic                ev_down_o,
  input logic [2:0]          pos_i,
  input logic [BTN_N-1:0]    pressed_i,
  input logic [BTN_N-1:0]    reported_i,
  input logic                pending_i,
  input logic [DELTA_W-1:0]  acc_x_i
);
  logic take, btn_byte, x_slot;
  assign take     = enable_i & byte_valid_i;
  assign btn_byte = (byte_i[7:3] == 5'b10000);
  assign x_slot   = take & ~byte_err_i & ~btn_byte &
                    ((pos_i == P_DX1) | (pos_i == P_DX2));

  p_btn_resync_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && !byte_err_i && btn_byte |=> pos_i == P_DX1);

  p_mask_decode_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && !byte_err_i && btn_byte |=> pressed_i == ~$past(byte_i[BTN_N-1:0]));

  p_err_unsync_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && byte_err_i |=> pos_i == P_UNSYNC);

  p_emit_after_fifth_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pending_i) |-> $past(take && !byte_err_i && !btn_byte && pos_i == P_DY2));

  p_btn_order_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_valid_o && ev_kind_o == EV_BTN |->
      (((pressed_i ^ reported_i) >> ev_btn_o) == 1) && ev_down_o == pressed_i[ev_btn_o]);

  p_x_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_valid_o && ev_kind_o == EV_DX && !x_slot |=> acc_x_i == '0);

  p_full_blocks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_full_i |-> !ev_valid_o);

  p_disabled_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> $stable(pos_i) && $stable(pressed_i));

  p_same_cycle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_valid_o && ev_kind_o == EV_DX && x_slot |=>
      $signed(acc_x_i) == $signed($past(byte_i)));
endmodule

bind mouse_pkt_decoder mouse_dec_checker #(.DELTA_W(DELTA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .enable_i     (enable_i),
  .byte_valid_i (byte_valid_i),
  .byte_i       (byte_i),
  .byte_err_i   (byte_err_i),
  .ev_full_i    (ev_full_i),
  .ev_valid_o   (ev_valid_o),
  .ev_kind_o    (ev_kind_o),
  .ev_btn_o     (ev_btn_o),
  .ev_down_o    (ev_down_o),
  .pos_i        (pos),
  .pressed_i    (pressed),
  .reported_i   (reported),
  .pending_i    (pending),
  .acc_x_i      (acc_x)
);

// File: tb/mouse_pkt_decoder_tb_top.sv
module mouse_pkt_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b1;
  logic        bvalid = 1'b0;
  logic [7:0]  bdata = '0;
  logic        berr = 1'b0;
  logic        full = 1'b0;
  logic        ev_valid;
  logic [1:0]  ev_kind, ev_btn;
  logic        ev_down;
  logic [15:0] ev_delta;

  always #5 clk = ~clk;

  mouse_pkt_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable),
    .byte_valid_i(bvalid), .byte_i(bdata), .byte_err_i(berr),
    .ev_full_i(full), .ev_valid_o(ev_valid), .ev_kind_o(ev_kind),
    .ev_btn_o(ev_btn), .ev_down_o(ev_down), .ev_delta_o(ev_delta)
  );

  typedef struct {
    logic [1:0] kind;
    logic [1:0] btn;
    logic       down;
    int         delta;
    string      req;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int fails  = 0;

  task automatic exp_btn(input int id, input bit down, input string req);
    exp_t e;
    e.kind = 2'd0; e.btn = 2'(id); e.down = down; e.delta = 0; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic exp_mv(input int kind, input int d, input string req);
    exp_t e;
    e.kind = 2'(kind); e.btn = '0; e.down = 1'b0; e.delta = d; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic send(input logic [7:0] b, input bit err);
    bvalid = 1'b1; bdata = b; berr = err;
    @(negedge clk);
    bvalid = 1'b0; berr = 1'b0;
  endtask

  task automatic pkt(input logic [7:0] b0, b1, b2, b3, b4);
    send(b0, 0); send(b1, 0); send(b2, 0); send(b3, 0); send(b4, 0);
  endtask

  task automatic drain(input string req);
    repeat (8) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL %s: events delivered actual=0 expected=%0d (missing)", req, exp_q.size());
      exp_q.delete();
    end
  endtask

  // scoreboard monitor
  always begin
    @(negedge clk);
    #1;
    if (rst_n && ev_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL unexpected event: actual kind=%0d btn=%0d down=%0d delta=%0d expected none",
                 ev_kind, ev_btn, ev_down, $signed(ev_delta));
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (ev_kind != e.kind ||
            (e.kind == 2'd0 && (ev_btn != e.btn || ev_down != e.down)) ||
            (e.kind != 2'd0 && $signed(ev_delta) != e.delta)) begin
          fails++;
          $display("FAIL %s: actual kind=%0d btn=%0d down=%0d delta=%0d expected kind=%0d btn=%0d down=%0d delta=%0d",
                   e.req, ev_kind, ev_btn, ev_down, $signed(ev_delta),
                   e.kind, e.btn, e.down, e.delta);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (ev_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1: ev_valid in reset actual=%b expected=0", ev_valid);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R1: nothing pressed, zero deltas -> no event
    pkt(8'h87, 8'h00, 8'h00, 8'h00, 8'h00);
    drain("R1");

    // R3 R5 R7 R8: left+right pressed, X=5+2, Y=-3+1
    exp_btn(2, 1, "R7"); exp_btn(0, 1, "R3");
    exp_mv(1, 7, "R5"); exp_mv(2, -2, "R8");
    pkt(8'h82, 8'h05, 8'hFD, 8'h02, 8'h01);
    drain("R8");

    exp_btn(2, 0, "R7"); exp_btn(0, 0, "R7");
    pkt(8'h87, 8'h00, 8'h00, 8'h00, 8'h00);
    drain("R7");

    // R2: resync mid-packet, earlier delta kept
    exp_btn(2, 1, "R2"); exp_mv(1, 18, "R2"); exp_mv(2, 2, "R2");
    send(8'h87, 0); send(8'h10, 0);
    pkt(8'h83, 8'h01, 8'h01, 8'h01, 8'h01);
    drain("R2");

    // R4: line error drops sync, following deltas discarded
    exp_btn(2, 0, "R4"); exp_mv(1, 4, "R4");
    send(8'h87, 0); send(8'h04, 0); send(8'h05, 1); send(8'h06, 0); send(8'h07, 0);
    pkt(8'h87, 8'h00, 8'h00, 8'h00, 8'h00);
    drain("R4");

    // R6: byte after fifth ignored
    exp_mv(1, 1, "R6");
    pkt(8'h87, 8'h01, 8'h00, 8'h00, 8'h00);
    send(8'h05, 0);
    pkt(8'h87, 8'h00, 8'h00, 8'h00, 8'h00);
    drain("R6");

    // R10: input while disabled has no effect
    enable = 1'b0;
    pkt(8'h80, 8'h0A, 8'h0A, 8'h0A, 8'h0A);
    enable = 1'b1;
    pkt(8'h87, 8'h00, 8'h00, 8'h00, 8'h00);
    drain("R10");

    // R9: full blocks, leftovers carried to later packet
    full = 1'b1;
    pkt(8'h84, 8'h03, 8'h00, 8'h00, 8'h00);
    drain("R9");
    full = 1'b0;
    exp_btn(1, 1, "R9"); exp_btn(0, 1, "R9"); exp_mv(1, 5, "R9");
    pkt(8'h84, 8'h02, 8'h00, 8'h00, 8'h00);
    drain("R9");
    exp_btn(1, 0, "R9"); exp_btn(0, 0, "R9");
    pkt(8'h87, 8'h00, 8'h00, 8'h00, 8'h00);
    drain("R9");

    // R11: saturation both ways
    full = 1'b1;
    for (int i = 0; i < 130; i++) pkt(8'h87, 8'h7F, 8'h00, 8'h7F, 8'h00);
    full = 1'b0;
    exp_mv(1, 32767, "R11");
    pkt(8'h87, 8'h00, 8'h00, 8'h00, 8'h00);
    drain("R11");
    full = 1'b1;
    for (int i = 0; i < 140; i++) pkt(8'h87, 8'h88, 8'h00, 8'h88, 8'h00);
    full = 1'b0;
    exp_mv(1, -32768, "R11");
    pkt(8'h87, 8'h00, 8'h00, 8'h00, 8'h00);
    drain("R11");

    // R12: delta-X byte lands in the cycle the X event leaves
    exp_btn(2, 1, "R12"); exp_mv(1, 9, "R12"); exp_mv(1, 3, "R12");
    pkt(8'h83, 8'h09, 8'h00, 8'h00, 8'h00);
    pkt(8'h83, 8'h03, 8'h00, 8'h00, 8'h00);
    drain("R12");
    exp_btn(2, 0, "R12");
    pkt(8'h87, 8'h00, 8'h00, 8'h00, 8'h00);
    drain("R12");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule